// File: doc/BRIEF.md
# Row-Column Spike Event Encoder

This block gathers spike events from a grid of sources, 3 columns by 5 rows by default, and reports them to a receiver through two sets of four-phase request/acknowledge channels. It has one channel per row and one per column. Each source has a single-rail request and acknowledge. A rising request places a pending spike in its grid cell and the block acknowledges it. The receiver first sees one request for every row that holds a pending spike. When it acknowledges a row, the block drops that row request and raises a column request for each pending cell in that row. Acknowledging a column clears that cell.

The block replaces an encoded address bus with per-line requests. The receiver decodes an event as a row line followed by one or more column lines. The block is fully synchronous to `clk`, and `rst` is active high. Every handshake input is sampled on the rising clock edge. Every request and acknowledge output comes straight from a flip-flop.

Top module: `spike_grid_encoder`

## Requirements
- R1: Input index i belongs to column i mod NCOL and row i div NCOL. With the defaults, inputs 0, 1 and 3 lie in row 0 column 0, row 0 column 1 and row 1 column 0.
- R2: While reset is high, and on the first edge after it, every request and input acknowledge output is low and no cell is pending, whatever the inputs were doing.
- R3: A source whose request is seen high, while its acknowledge is low and its cell is empty, gets its acknowledge high and its cell marked pending on that edge. The acknowledge returns low on the edge that sees the request low, and the cell stays pending.
- R4: A row request is high on the edge after its row holds a pending cell while that row's acknowledge is low. All such rows request at the same time. No column request is raised by row requests alone.
- R5: On the edge that sees a row acknowledge high, that row request goes low. Column requests go high for exactly the pending columns of the selected row.
- R6: On an edge that sees a column acknowledge high while that column request is high, the request goes low and the selected row's cell in that column is cleared. The request stays low after the acknowledge falls.
- R7: A pending row keeps its request high while another row is served. Its column requests appear only once its own acknowledge is high.
- R8: A request held high after its spike has been served creates no second event. A new capture needs the request to fall and rise again.
- R9: Column requests are driven only while some row acknowledge is high. When several are high, the lowest-numbered row is the one selected.
- R10: A request that rises again while its cell is still pending is not acknowledged. Its acknowledge rises on the edge after the cell is cleared, and the cell becomes pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_req | input | NCOL*NROW | Source spike requests, one per grid cell |
| in_ack | output | NCOL*NROW | Source acknowledges |
| row_req | output | NROW | Row event requests |
| row_ack | input | NROW | Row acknowledges from the receiver |
| col_req | output | NCOL | Column event requests for the selected row |
| col_ack | input | NCOL | Column acknowledges from the receiver |

## Verification
A source acknowledge answers its request one edge after the request is seen. A row request follows a capture two edges after the source request is applied, because the capture and the row flag are each registered. A row acknowledge lowers the row request and raises the column requests one edge later. A column acknowledge lowers its request and clears the cell on a single edge. The bench drives every input just after a falling edge. A behavioural model advances on each rising edge, and every output is compared with it at the next falling edge. This places each comparison exactly one register stage after the stimulus that caused it. The scripted checks count the same edges: two ticks between a source request and its row request, one tick for each other response.

// File: rtl/spike_grid_pkg.sv
package spike_grid_pkg;
  localparam int unsigned GRID_COLS = 3;
  localparam int unsigned GRID_ROWS = 5;
endpackage

// File: rtl/spike_cell.sv
// One grid cell: four-phase source handshake plus the pending-spike flag.
module spike_cell (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic clr_i,
  output logic ack_o,
  output logic pend_o
);
  logic take;

  // A capture needs an idle handshake and an empty cell (no double counting).
  assign take = req_i & ~ack_o & ~pend_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      ack_o  <= take | (ack_o & req_i);
      pend_o <= take | (pend_o & ~clr_i);
    end
  end
endmodule

// File: rtl/spike_row_scan.sv
// Row request lines: one per row that holds a pending cell and is not acknowledged.
module spike_row_scan #(
  parameter int unsigned NCOL = 3,
  parameter int unsigned NROW = 5,
  localparam int unsigned NCELL = NCOL * NROW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCELL-1:0] pend,
  input  logic [NROW-1:0]  row_ack,
  output logic [NROW-1:0]  row_req
);
  logic [NROW-1:0] occupied;

  for (genvar r = 0; r < NROW; r++) begin : g_row
    assign occupied[r] = |pend[r*NCOL +: NCOL];

    always_ff @(posedge clk) begin
      if (rst) row_req[r] <= 1'b0;
      else     row_req[r] <= occupied[r] & ~row_ack[r];
    end
  end
endmodule

// File: rtl/spike_col_drive.sv
// Column request lines for the lowest acknowledged row, and per-cell clear strobes.
module spike_col_drive #(
  parameter int unsigned NCOL = 3,
  parameter int unsigned NROW = 5,
  localparam int unsigned NCELL = NCOL * NROW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCELL-1:0] pend,
  input  logic [NROW-1:0]  row_ack,
  input  logic [NCOL-1:0]  col_ack,
  output logic [NCOL-1:0]  col_req,
  output logic [NCELL-1:0] clr
);
  logic [NROW-1:0] sel_oh;
  logic [NCOL-1:0] sel_pend;

  // Lowest set bit of the acknowledge vector picks the served row.
  assign sel_oh = row_ack & (~row_ack + 1'b1);

  always_comb begin
    sel_pend = '0;
    for (int r = 0; r < NROW; r++) begin
      if (sel_oh[r]) sel_pend = sel_pend | pend[r*NCOL +: NCOL];
    end
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    always_ff @(posedge clk) begin
      if (rst) col_req[c] <= 1'b0;
      else     col_req[c] <= sel_pend[c] & ~col_ack[c];
    end
  end

  for (genvar r = 0; r < NROW; r++) begin : g_clr_r
    for (genvar c = 0; c < NCOL; c++) begin : g_clr_c
      assign clr[r*NCOL + c] = sel_oh[r] & col_ack[c] & col_req[c];
    end
  end
endmodule

// File: rtl/spike_grid_encoder.sv
module spike_grid_encoder #(
  parameter int unsigned NCOL = spike_grid_pkg::GRID_COLS,
  parameter int unsigned NROW = spike_grid_pkg::GRID_ROWS,
  localparam int unsigned NCELL = NCOL * NROW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCELL-1:0] in_req,
  output logic [NCELL-1:0] in_ack,
  output logic [NROW-1:0]  row_req,
  input  logic [NROW-1:0]  row_ack,
  output logic [NCOL-1:0]  col_req,
  input  logic [NCOL-1:0]  col_ack
);
  logic [NCELL-1:0] pend;
  logic [NCELL-1:0] clr;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    spike_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .req_i (in_req[i]),
      .clr_i (clr[i]),
      .ack_o (in_ack[i]),
      .pend_o(pend[i])
    );
  end

  spike_row_scan #(.NCOL(NCOL), .NROW(NROW)) u_rows (
    .clk    (clk),
    .rst    (rst),
    .pend   (pend),
    .row_ack(row_ack),
    .row_req(row_req)
  );

  spike_col_drive #(.NCOL(NCOL), .NROW(NROW)) u_cols (
    .clk    (clk),
    .rst    (rst),
    .pend   (pend),
    .row_ack(row_ack),
    .col_ack(col_ack),
    .col_req(col_req),
    .clr    (clr)
  );
endmodule

// File: rtl/spike_grid_encoder_chk.sv
module spike_grid_encoder_chk #(
  parameter int unsigned NCOL = 3,
  parameter int unsigned NROW = 5,
  localparam int unsigned NCELL = NCOL * NROW
) (
  input logic             clk,
  input logic             rst,
  input logic [NCELL-1:0] in_req,
  input logic [NCELL-1:0] in_ack,
  input logic [NROW-1:0]  row_req,
  input logic [NROW-1:0]  row_ack,
  input logic [NCOL-1:0]  col_req,
  input logic [NCOL-1:0]  col_ack
);
  // R2: first sample after reset shows every output idle
  a_r2_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (row_req == '0 && col_req == '0 && in_ack == '0));

  // R9: column lines only follow an acknowledged row
  a_r9_col_needs_row: assert property (@(posedge clk) disable iff (rst)
    (col_req != '0) |-> $past(row_ack != '0));

  for (genvar i = 0; i < NCELL; i++) begin : g_src
    // R3: acknowledge rises only in answer to a high request
    a_r3_ack_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(in_ack[i]) |-> $past(in_req[i]));
    // R3: acknowledge falls only after the request was seen low
    a_r3_ack_fall: assert property (@(posedge clk) disable iff (rst)
      $fell(in_ack[i]) |-> !$past(in_req[i]));
  end

  for (genvar r = 0; r < NROW; r++) begin : g_row
    // R5: an acknowledged row stops requesting on the next edge
    a_r5_row_drop: assert property (@(posedge clk) disable iff (rst)
      row_ack[r] |=> !row_req[r]);
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    // R6: an acknowledged column request drops on the next edge
    a_r6_col_drop: assert property (@(posedge clk) disable iff (rst)
      (col_ack[c] && col_req[c]) |=> !col_req[c]);
  end
endmodule

bind spike_grid_encoder spike_grid_encoder_chk #(.NCOL(NCOL), .NROW(NROW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .in_req (in_req),
  .in_ack (in_ack),
  .row_req(row_req),
  .row_ack(row_ack),
  .col_req(col_req),
  .col_ack(col_ack)
);

// File: tb/spike_grid_encoder_test.sv
module spike_grid_encoder_test;
  localparam int PERIOD = 10;
  localparam int NC = 3;
  localparam int NR = 5;
  localparam int N  = NC * NR;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  in_req = '0;
  logic [N-1:0]  in_ack;
  logic [NR-1:0] row_req;
  logic [NR-1:0] row_ack = '0;
  logic [NC-1:0] col_req;
  logic [NC-1:0] col_ack = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  spike_grid_encoder uut (
    .clk(clk), .rst(rst), .in_req(in_req), .in_ack(in_ack),
    .row_req(row_req), .row_ack(row_ack), .col_req(col_req), .col_ack(col_ack)
  );

  always #(PERIOD/2) clk = ~clk;

  // Behavioural reference: pending flags, source acks and request lines as plain ints.
  int m_pend[N];
  int m_ack[N];
  int m_rreq[NR];
  int m_creq[NC];

  always @(posedge clk) begin : model
    int sel;
    int np[N];
    int na[N];
    sel = -1;
    for (int r = NR - 1; r >= 0; r--) if (row_ack[r]) sel = r;
    for (int i = 0; i < N; i++) begin
      bit cap, clear;
      cap   = in_req[i] && !m_ack[i] && !m_pend[i];
      clear = (sel >= 0) && (i / NC == sel) && col_ack[i % NC] && (m_creq[i % NC] != 0);
      na[i] = cap ? 1 : ((in_req[i] && m_ack[i]) ? 1 : 0);
      np[i] = cap ? 1 : ((m_pend[i] && !clear) ? 1 : 0);
    end
    for (int r = 0; r < NR; r++) begin
      int any;
      any = 0;
      for (int c = 0; c < NC; c++) if (m_pend[r*NC + c]) any = 1;
      m_rreq[r] = (any && !row_ack[r]) ? 1 : 0;
    end
    for (int c = 0; c < NC; c++)
      m_creq[c] = (sel >= 0 && m_pend[sel*NC + c] && !col_ack[c]) ? 1 : 0;
    for (int i = 0; i < N; i++) begin
      m_pend[i] = rst ? 0 : np[i];
      m_ack[i]  = rst ? 0 : na[i];
    end
    if (rst) begin
      for (int r = 0; r < NR; r++) m_rreq[r] = 0;
      for (int c = 0; c < NC; c++) m_creq[c] = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin : cmp
    logic [N-1:0]  ea;
    logic [NR-1:0] er;
    logic [NC-1:0] ec;
    if (!rst && !done) begin
      for (int i = 0; i < N; i++)  ea[i] = (m_ack[i] != 0);
      for (int r = 0; r < NR; r++) er[r] = (m_rreq[r] != 0);
      for (int c = 0; c < NC; c++) ec[c] = (m_creq[c] != 0);
      chk("R3 model in_ack", 32'(in_ack), 32'(ea));
      chk("R4 model row_req", 32'(row_req), 32'(er));
      chk("R5 model col_req", 32'(col_req), 32'(ec));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin : stim
    // R2: inputs busy during reset must leave no trace
    in_req  = 15'h7fff;
    row_ack = 5'h1f;
    col_ack = 3'h7;
    tick(3);
    in_req  = '0;
    row_ack = '0;
    col_ack = '0;
    tick(1);
    rst = 1'b0;
    chk("R2 reset row_req", 32'(row_req), 32'h0);
    chk("R2 reset col_req", 32'(col_req), 32'h0);
    chk("R2 reset in_ack",  32'(in_ack),  32'h0);
    tick(2);
    chk("R2 no pending after reset", 32'(row_req), 32'h0);

    // R1, R3, R4: sources 0, 1, 3
    in_req = 15'h000b;
    tick(1);
    chk("R3 ack rise", 32'(in_ack), 32'h000b);
    chk("R4 no row yet", 32'(row_req), 32'h0);
    tick(1);
    chk("R1 rows 0 and 1 request", 32'(row_req), 32'h03);
    chk("R4 no column without row ack", 32'(col_req), 32'h0);
    in_req = '0;
    tick(1);
    chk("R3 ack fall", 32'(in_ack), 32'h0);
    chk("R3 still pending", 32'(row_req), 32'h03);

    // R5, R6, R7: serve row 0
    row_ack = 5'h01;
    tick(1);
    chk("R5 row 0 drops", 32'(row_req), 32'h02);
    chk("R5 columns 0 and 1", 32'(col_req), 32'h3);
    col_ack = 3'h1;
    tick(1);
    chk("R6 column 0 drops", 32'(col_req), 32'h2);
    col_ack = 3'h0;
    tick(1);
    chk("R6 column 0 stays low", 32'(col_req), 32'h2);
    col_ack = 3'h2;
    tick(1);
    chk("R6 column 1 drops", 32'(col_req), 32'h0);
    chk("R7 row 1 waits", 32'(row_req), 32'h02);
    row_ack = '0;
    col_ack = '0;
    tick(1);
    chk("R7 row 0 cleared, row 1 pending", 32'(row_req), 32'h02);
    row_ack = 5'h02;
    tick(1);
    chk("R7 row 1 served", 32'(row_req), 32'h0);
    chk("R1 row 1 column 0", 32'(col_req), 32'h1);
    col_ack = 3'h1;
    tick(1);
    chk("R6 row 1 column 0 drops", 32'(col_req), 32'h0);
    row_ack = '0;
    col_ack = '0;
    tick(2);
    chk("R6 grid empty", 32'(row_req), 32'h0);

    // R8: request on source 14 held high through service
    in_req[14] = 1'b1;
    tick(2);
    chk("R8 row 4 request", 32'(row_req), 32'h10);
    row_ack = 5'h10;
    tick(1);
    chk("R8 column 2", 32'(col_req), 32'h4);
    col_ack = 3'h4;
    tick(1);
    row_ack = '0;
    col_ack = '0;
    tick(4);
    chk("R8 no second row event", 32'(row_req), 32'h0);
    chk("R8 ack stays high", 32'(in_ack[14]), 32'h1);
    in_req[14] = 1'b0;
    tick(1);
    chk("R8 ack falls", 32'(in_ack[14]), 32'h0);

    // R10: source 5 re-requests while pending
    in_req[5] = 1'b1;
    tick(1);
    in_req[5] = 1'b0;
    tick(1);
    in_req[5] = 1'b1;
    tick(3);
    chk("R10 ack held off", 32'(in_ack[5]), 32'h0);
    row_ack = 5'h02;
    tick(1);
    col_ack = 3'h4;
    tick(1);
    chk("R10 ack still low on clear edge", 32'(in_ack[5]), 32'h0);
    tick(1);
    chk("R10 ack after clear", 32'(in_ack[5]), 32'h1);
    col_ack = '0;
    tick(1);
    chk("R10 new event offered", 32'(col_req), 32'h4);
    col_ack = 3'h4;
    tick(1);
    in_req[5] = 1'b0;
    row_ack = '0;
    col_ack = '0;
    tick(2);
    chk("R10 drained", 32'(row_req), 32'h0);

    // R9: sources 2 (row 0 col 2) and 4 (row 1 col 1), both rows acked
    in_req = 15'h0014;
    tick(1);
    in_req = '0;
    tick(2);
    row_ack = 5'h03;
    tick(1);
    chk("R9 lowest row wins", 32'(col_req), 32'h4);
    col_ack = 3'h4;
    tick(1);
    col_ack = '0;
    tick(1);
    chk("R9 row 1 not yet", 32'(col_req), 32'h0);
    row_ack = 5'h02;
    tick(1);
    chk("R9 row 1 column 1", 32'(col_req), 32'h2);
    col_ack = 3'h2;
    tick(1);
    row_ack = '0;
    col_ack = '0;
    tick(2);
    chk("R9 drained", 32'(row_req | col_req), 32'h0);

    // Random traffic, compared every clock against the model
    for (int k = 0; k < 4000; k++) begin
      for (int i = 0; i < N; i++)
        if ($urandom_range(0, 7) == 0) in_req[i] = ~in_req[i];
      if ($urandom_range(0, 3) == 0) row_ack = 5'(1 << $urandom_range(0, NR - 1));
      else if ($urandom_range(0, 3) == 0) row_ack = '0;
      else if ($urandom_range(0, 15) == 0) row_ack = 5'($urandom_range(0, 31));
      col_ack = 3'($urandom_range(0, 7)) & (col_req | 3'($urandom_range(0, 1)));
      tick(1);
    end

    finish_run();
  end
endmodule